// File: doc/BRIEF.md
# Key-protected control register file

A bank of 32-bit control words on a simple word-addressed bus. Each access carries a request strobe, a write flag, a 12-bit byte offset and write data. Read data is registered and appears in the cycle after the request. An unlock key word gates writes to the lower part of the bank. A set of status locations cannot be written. One location hands out a fresh pseudo-random word on every read. A strap word has set-only and clear-only access paths on the newer silicon variant.

The silicon-revision parameter picks the variant and, with it, the table of reset values. The revision, both strap words and the key word take their reset value from their own parameters. Every rejected access raises a one-cycle error pulse and a sticky error bit. The sticky bit stays set until reset. The clock, reset, pin-mux and bus-bridge functions that software steers through these words are not part of this block.

Top module: `ctlreg_bank`

## Requirements
- R1: The word index is the byte offset shifted right by 2, and the region spans 0x1000 bytes. An access whose two low offset bits are not zero is invalid: a write to it is ignored, a read of it returns 0, and it raises the error pulse.
- R2: A write to offset 0x00 stores 1 if the data equals the parameter UNLOCK_KEY and stores 0 otherwise. The written word itself is never kept.
- R3: While the word at 0x00 is zero, writes to offsets 0x04 through 0x100 are discarded and raise the error pulse. Offsets from 0x104 upward stay writable.
- R4: An offset at or beyond NUM_REGS*4 (0x1A8 by default) reads as 0, ignores writes, and raises the error pulse. The last word, 0x1A4, is a normal location.
- R5: Writes to 0x14, to 0x50 through 0x6C, to 0x78, to 0xE0 and to 0xE4 are dropped and raise the error pulse.
- R6: Each read of 0x78 advances a 32-bit LFSR by one step and returns the new state. The LFSR is seeded with LFSR_SEED at reset, and one step maps s to {s[30:0], s[31]^s[21]^s[1]^s[0]}. The contents of 0x74 have no effect on this.
- R7: On the newer variant (REV_WORD[31:24] >= NEWER_GEN_MIN), a write to 0x70 ORs the data into the strap word. A write to 0x7C clears the strap bits that are 1 in the data, leaves the revision word unchanged and raises no error.
- R8: On the older variant, a write to 0x70 stores the data as given. A write to 0x7C is dropped and raises the error pulse.
- R9: On reset, 0x00 loads KEY_RESET, 0x70 loads STRAP1_RESET, 0xD0 loads STRAP2_RESET and 0x7C loads REV_WORD. Every other word loads its variant table value: for example, 0x04 loads 0xFFCFFEDC, 0x08 loads 0xF3F40000, and 0x24 loads 0x93000400 on the newer variant or 0x00000291 on the older one.
- R10: A read of 0xC0 raises the error pulse but still returns the stored word. A write to 0xC0 stores normally.
- R11: err_pulse is high for exactly the one cycle after a rejected access. err_sticky sets with it and holds until reset.
- R12: Any other location accepts writes, subject to R3, and a read returns its word on bus_rdata in the cycle after the request. bus_rdata holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| err_pulse | output | 1 | One-cycle pulse for a rejected access |
| err_sticky | output | 1 | Error seen since reset |

## Verification
The assertions check the following on every cycle:
- the key word only ever holds 0 or 1 after it is written;
- a locked write leaves the strap word untouched and raises an error;
- reads beyond the bank return zero;
- the random word on the bus equals the new LFSR state;
- on the newer variant, a strap write never clears a bit;
- the sticky error bit never drops.

Only the bench's directed scenarios can show that the reset table values, the exact random sequence, and the difference between the two variants in the strap and revision paths come out as specified. The same holds for the wake-up read flag that still returns data, and for the re-locking that follows a wrong key.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

   // Word indices whose behaviour differs from a plain store
   localparam int unsigned IDX_KEY     = 0;
   localparam int unsigned IDX_FCNT    = 5;
   localparam int unsigned IDX_VSCR_LO = 20;
   localparam int unsigned IDX_VSCR_HI = 27;
   localparam int unsigned IDX_STRAP1  = 28;
   localparam int unsigned IDX_RNG     = 30;
   localparam int unsigned IDX_REV     = 31;
   localparam int unsigned IDX_WAKE    = 48;
   localparam int unsigned IDX_STRAP2  = 52;
   localparam int unsigned IDX_FREE_LO = 56;
   localparam int unsigned IDX_FREE_HI = 57;

   typedef enum logic [2:0] {
      K_PLAIN,
      K_KEY,
      K_RO,
      K_STRAP,
      K_REV,
      K_RNG,
      K_WAKE
   } acc_kind_e;

   // Reset table, one entry per word index; unlisted words reset to zero
   function automatic logic [31:0] table_word(input int unsigned idx, input bit newer);
      logic [31:0] w;
      case (idx)
         9:       w = newer ? 32'h9300_0400 : 32'h0000_0291;
         34:      w = newer ? 32'h0300_0000 : 32'h0100_0000;
         35:      w = newer ? 32'h0000_0000 : 32'h0000_00FF;
         39:      w = newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
         105:     w = 32'h0000_2402;
         96:      w = 32'h0000_007B;
         88:      w = 32'h0000_1903;
         65:      w = 32'h8000_0000;
         68:      w = 32'h1E60_0000;
         69:      w = 32'hC000_0000;
         56, 57:  w = 32'h0000_00FF;
         41:      w = 32'hFFFF_0000;
         42:      w = 32'h000F_FFFF;
         33:      w = 32'h0000_F000;
         36:      w = 32'h0000_A000;
         29:      w = 32'h0000_000E;
         19:      w = 32'h0000_0023;
         16:      w = 32'h0000_00C0;
         15:      w = 32'h0000_0001;
         12, 13:  w = 32'h2000_1A03;
         14:      w = 32'h0400_0030;
         11:      w = 32'h0000_0010;
         7:       w = 32'h0002_6108;
         8:       w = 32'h0003_0291;
         3:       w = 32'h19FC_3E8B;
         2:       w = 32'hF3F4_0000;
         1:       w = 32'hFFCF_FEDC;
         default: w = 32'h0000_0000;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/ctlreg_decode.sv
module ctlreg_decode
   import ctlreg_pkg::*;
#(
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned NUM_REGS     = 106,
   parameter int unsigned LOCK_END_IDX = 65,
   parameter bit          NEWER        = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-3:0] idx,
   output logic              valid,
   output logic              in_zone,
   output acc_kind_e         kind,
   output logic              wr_ro
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [31:0] idx_u;

   assign idx     = addr[ADDR_W-1:2];
   assign idx_u   = 32'(idx);
   // R1, R4: aligned and inside the implemented bank
   assign valid   = (addr[1:0] == 2'b00) && (idx_u < NUM_REGS);
   // R3: lock zone excludes the key word itself
   assign in_zone = (idx != IDX_W'(0)) && (idx_u < LOCK_END_IDX);

   always_comb begin
      kind = K_PLAIN;
      if (idx_u == IDX_KEY)                                   kind = K_KEY;
      else if (idx_u == IDX_FCNT)                             kind = K_RO;
      else if (idx_u >= IDX_VSCR_LO && idx_u <= IDX_VSCR_HI)  kind = K_RO;
      else if (idx_u == IDX_FREE_LO || idx_u == IDX_FREE_HI)  kind = K_RO;
      else if (idx_u == IDX_RNG)                              kind = K_RNG;
      else if (idx_u == IDX_STRAP1)                           kind = K_STRAP;
      else if (idx_u == IDX_REV)                              kind = K_REV;
      else if (idx_u == IDX_WAKE)                             kind = K_WAKE;
   end

   // R5, R8: locations that refuse writes; the revision word only on the older variant
   assign wr_ro = (kind == K_RO) || (kind == K_RNG) || ((kind == K_REV) && !NEWER);

endmodule

// File: rtl/ctlreg_lfsr.sv
module ctlreg_lfsr #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] SEED = 32'h1D87_2B41
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic [W-1:0] state,
   output logic [W-1:0] next
);
   if (W != 32) begin : g_chk_w
      $error("ctlreg_lfsr: feedback taps are defined for W == 32 only");
   end
   if (SEED == '0) begin : g_chk_seed
      $error("ctlreg_lfsr: SEED must be non-zero");
   end

   // x^32 + x^22 + x^2 + x + 1, shifting toward the MSB
   assign next = {state[W-2:0], state[31] ^ state[21] ^ state[1] ^ state[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= next;
   end

   // R6: a maximal-length sequence never reaches the all-zero state
   a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

   // R6: every step moves the state
   a_r6_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> state != $past(state));

endmodule

// File: rtl/ctlreg_cell.sv
module ctlreg_cell #(
   parameter int unsigned  W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
   import ctlreg_pkg::*;
#(
   parameter int unsigned ADDR_W        = 12,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned NUM_REGS      = 106,
   parameter int unsigned LOCK_END_IDX  = 65,
   parameter logic [31:0] UNLOCK_KEY    = 32'hC0DE_5A17,
   parameter logic [31:0] KEY_RESET     = 32'h0000_0000,
   parameter logic [31:0] STRAP1_RESET  = 32'h0000_0F00,
   parameter logic [31:0] STRAP2_RESET  = 32'h0000_00A5,
   parameter logic [31:0] REV_WORD      = 32'h0400_0103,
   parameter logic [7:0]  NEWER_GEN_MIN = 8'h04,
   parameter logic [31:0] LFSR_SEED     = 32'h1D87_2B41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              err_pulse,
   output logic              err_sticky
);
   localparam int unsigned IDX_W    = ADDR_W - 2;
   localparam bit          IS_NEWER = (REV_WORD[31:24] >= NEWER_GEN_MIN);

   // Elaboration-time parameter checks
   if (DATA_W != 32) begin : g_chk_data
      $error("ctlreg_bank: DATA_W must be 32");
   end
   if (ADDR_W < 3 || NUM_REGS > (1 << (ADDR_W - 2))) begin : g_chk_addr
      $error("ctlreg_bank: NUM_REGS does not fit the address space");
   end
   if (NUM_REGS <= IDX_FREE_HI) begin : g_chk_depth
      $error("ctlreg_bank: NUM_REGS too small for the special locations");
   end
   if (LOCK_END_IDX < 1 || LOCK_END_IDX > NUM_REGS) begin : g_chk_lock
      $error("ctlreg_bank: LOCK_END_IDX out of range");
   end

   // ---------------- decode ----------------
   logic [IDX_W-1:0] dec_idx;
   logic             dec_valid;
   logic             dec_in_zone;
   acc_kind_e        dec_kind;
   logic             dec_wr_ro;

   ctlreg_decode #(
      .ADDR_W      (ADDR_W),
      .NUM_REGS    (NUM_REGS),
      .LOCK_END_IDX(LOCK_END_IDX),
      .NEWER       (IS_NEWER)
   ) u_dec (
      .addr   (bus_addr),
      .idx    (dec_idx),
      .valid  (dec_valid),
      .in_zone(dec_in_zone),
      .kind   (dec_kind),
      .wr_ro  (dec_wr_ro)
   );

   // ---------------- storage and write control ----------------
   logic [DATA_W-1:0] regs [NUM_REGS];
   logic              locked;
   logic              blocked;
   logic              wr_ok;

   assign locked  = (regs[IDX_KEY] == '0);
   assign blocked = dec_in_zone && locked;
   assign wr_ok   = bus_req && bus_wr && dec_valid && !blocked && !dec_wr_ro;

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [DATA_W-1:0] RV =
         (gi == IDX_KEY)    ? KEY_RESET    :
         (gi == IDX_STRAP1) ? STRAP1_RESET :
         (gi == IDX_STRAP2) ? STRAP2_RESET :
         (gi == IDX_REV)    ? REV_WORD     :
                              table_word(gi, IS_NEWER);
      logic              we;
      logic [DATA_W-1:0] d;

      if (gi == IDX_RNG || gi == IDX_REV) begin : g_fixed
         // Random word comes from the LFSR; revision is never stored to
         assign we = 1'b0;
         assign d  = regs[gi];
      end else if (gi == IDX_KEY) begin : g_key
         logic hit;
         assign hit = (dec_idx == IDX_W'(gi));
         assign we  = wr_ok && hit;
         assign d   = (bus_wdata == UNLOCK_KEY) ? DATA_W'(1) : '0;
      end else if (gi == IDX_STRAP1 && IS_NEWER) begin : g_strap_sc
         logic hit;
         assign hit = (dec_idx == IDX_W'(gi));
         assign we  = wr_ok && (hit || dec_kind == K_REV);
         assign d   = (dec_kind == K_REV) ? (regs[gi] & ~bus_wdata)
                                          : (regs[gi] | bus_wdata);
      end else begin : g_plain
         logic hit;
         assign hit = (dec_idx == IDX_W'(gi));
         assign we  = wr_ok && hit;
         assign d   = bus_wdata;
      end

      ctlreg_cell #(.W(DATA_W), .RST(RV)) u_cell (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (we),
         .d    (d),
         .q    (regs[gi])
      );
   end

   // ---------------- random source ----------------
   logic              rng_step;
   logic [DATA_W-1:0] lfsr_state;
   logic [DATA_W-1:0] lfsr_next;

   assign rng_step = bus_req && !bus_wr && dec_valid && (dec_kind == K_RNG);

   ctlreg_lfsr #(.W(DATA_W), .SEED(LFSR_SEED)) u_lfsr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (rng_step),
      .state(lfsr_state),
      .next (lfsr_next)
   );

   // ---------------- read path ----------------
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] rdata_q;

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < int'(NUM_REGS); i++) begin
         if (dec_idx == IDX_W'(i)) rd_word = regs[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_req && !bus_wr) begin
         if (!dec_valid)              rdata_q <= '0;
         else if (dec_kind == K_RNG)  rdata_q <= lfsr_next;
         else                         rdata_q <= rd_word;
      end
   end
   assign bus_rdata = rdata_q;

   // ---------------- error reporting ----------------
   logic err_now;
   logic err_q;
   logic sticky_q;

   assign err_now = bus_req && (!dec_valid
                                || (bus_wr && (blocked || dec_wr_ro))
                                || (!bus_wr && dec_kind == K_WAKE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q    <= 1'b0;
         sticky_q <= 1'b0;
      end else begin
         err_q    <= err_now;
         sticky_q <= sticky_q | err_now;
      end
   end
   assign err_pulse  = err_q;
   assign err_sticky = sticky_q;

   // ---------------- assertions ----------------
   // R2: the key word is only ever 0 or 1 after a key write
   a_r2_key_binary: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == '0) |=> (regs[IDX_KEY] <= DATA_W'(1)));

   // R3: a locked write to the strap word leaves it and flags an error
   a_r3_locked_strap: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == ADDR_W'(IDX_STRAP1 * 4) && regs[IDX_KEY] == '0)
      |=> (regs[IDX_STRAP1] == $past(regs[IDX_STRAP1]) && err_pulse));

   // R4: reads beyond the bank return zero and flag an error
   a_r4_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && 32'(bus_addr) >= NUM_REGS * 4)
      |=> (bus_rdata == '0 && err_pulse));

   // R5: a write to the frequency-counter result is flagged
   a_r5_ro_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_wr && bus_addr == ADDR_W'(IDX_FCNT * 4)) |=> err_pulse);

   // R6: the random word returned equals the advanced LFSR state
   a_r6_rng_data: assert property (@(posedge clk) disable iff (!rst_n)
      rng_step |=> bus_rdata == lfsr_state);

   // R11: the sticky bit never drops outside reset
   a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);

   if (IS_NEWER) begin : g_newer_chk
      // R7: writes to the strap address only ever add bits
      a_r7_strap_set_only: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && bus_wr && bus_addr == ADDR_W'(IDX_STRAP1 * 4))
         |=> ((regs[IDX_STRAP1] & $past(regs[IDX_STRAP1])) == $past(regs[IDX_STRAP1])));
   end else begin : g_older_chk
      // R8: a write to the revision address is flagged on the older variant
      a_r8_rev_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && bus_wr && bus_addr == ADDR_W'(IDX_REV * 4)) |=> err_pulse);
   end

endmodule

// File: tb/ctlreg_bank_tb.sv
module ctlreg_bank_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          WD_CYCLES  = 20000;
   localparam logic [31:0] KEY        = 32'hC0DE_5A17;
   localparam logic [31:0] SEED       = 32'h1D87_2B41;
   localparam logic [31:0] REV_NEW    = 32'h0400_0103;
   localparam logic [31:0] REV_OLD    = 32'h0200_0103;
   localparam logic [31:0] S1         = 32'h0000_0F00;
   localparam logic [31:0] S2         = 32'h0000_00A5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rd_n, rd_o;
   logic        ep_n, ep_o, es_n, es_o;

   int checks = 0;
   int errors = 0;
   logic [31:0] got_n, got_o;
   logic        gerr_n, gerr_o;
   logic [31:0] rng_ref;

   always #(CLK_PERIOD/2) clk = ~clk;

   ctlreg_bank #(.UNLOCK_KEY(KEY), .REV_WORD(REV_NEW), .STRAP1_RESET(S1),
                 .STRAP2_RESET(S2), .LFSR_SEED(SEED)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_n),
      .err_pulse(ep_n), .err_sticky(es_n));

   ctlreg_bank #(.UNLOCK_KEY(KEY), .REV_WORD(REV_OLD), .STRAP1_RESET(S1),
                 .STRAP2_RESET(S2), .LFSR_SEED(SEED)) old_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_o),
      .err_pulse(ep_o), .err_sticky(es_o));

   function automatic logic [31:0] lfsr_adv(input logic [31:0] s);
      return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
      gerr_n = ep_n; gerr_o = ep_o;
   endtask

   task automatic rd(input logic [11:0] a);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      got_n = rd_n; got_o = rd_o; gerr_n = ep_n; gerr_o = ep_o;
   endtask

   task automatic t_reset_vals();
      check("R11 sticky clear after reset", 32'(es_n), 0);
      rd(12'h000); check("R9 key reset", got_n, 32'h0);
      rd(12'h004); check("R9 table 0x04", got_n, 32'hFFCF_FEDC);
      rd(12'h008); check("R9 table 0x08", got_o, 32'hF3F4_0000);
      rd(12'h024); check("R9 newer 0x24", got_n, 32'h9300_0400);
                   check("R9 older 0x24", got_o, 32'h0000_0291);
      rd(12'h07C); check("R9 rev newer", got_n, REV_NEW);
                   check("R9 rev older", got_o, REV_OLD);
      rd(12'h070); check("R9 strap1", got_n, S1);
      rd(12'h0D0); check("R9 strap2", got_o, S2);
      check("R12 no error on plain reads", 32'(es_n), 0);
   endtask

   task automatic t_locked();
      wr(12'h008, 32'h1234_5678); check("R3 locked write flagged", 32'(gerr_n), 1);
      rd(12'h008); check("R3 locked write discarded", got_n, 32'hF3F4_0000);
      wr(12'h100, 32'h0000_0001); check("R3 last locked offset flagged", 32'(gerr_o), 1);
      wr(12'h104, 32'h1234_ABCD); check("R3 0x104 writable while locked", 32'(gerr_n), 0);
      rd(12'h104); check("R12 readback 0x104", got_n, 32'h1234_ABCD);
   endtask

   task automatic t_key();
      wr(12'h000, 32'hDEAD_BEEF); rd(12'h000); check("R2 wrong key stores 0", got_n, 0);
      wr(12'h000, KEY);           rd(12'h000); check("R2 right key stores 1", got_n, 1);
      wr(12'h008, 32'h0BAD_F00D); check("R12 unlocked write no error", 32'(gerr_n), 0);
      rd(12'h008); check("R12 unlocked readback", got_o, 32'h0BAD_F00D);
      @(negedge clk); check("R12 rdata holds", rd_n, 32'h0BAD_F00D);
   endtask

   task automatic t_readonly();
      wr(12'h014, 32'hFFFF_FFFF); check("R5 0x14 flagged", 32'(gerr_n), 1);
      rd(12'h014); check("R5 0x14 unchanged", got_n, 0);
      wr(12'h06C, 32'hFFFF_FFFF); check("R5 0x6C flagged", 32'(gerr_n), 1);
      rd(12'h06C); check("R5 0x6C unchanged", got_n, 0);
      wr(12'h050, 32'h1); check("R5 0x50 flagged", 32'(gerr_o), 1);
      wr(12'h0E4, 32'h0); check("R5 0xE4 flagged", 32'(gerr_n), 1);
      rd(12'h0E4); check("R5 0xE4 unchanged", got_n, 32'hFF);
      wr(12'h078, 32'h0); check("R5 0x78 flagged", 32'(gerr_n), 1);
   endtask

   task automatic t_bounds();
      wr(12'h1A8, 32'h5); check("R4 write past end flagged", 32'(gerr_n), 1);
      rd(12'h1A8); check("R4 read past end is 0", got_n, 0);
                   check("R4 read past end flagged", 32'(gerr_n), 1);
      rd(12'hFFC); check("R4 read top of region is 0", got_o, 0);
      rd(12'h1A4); check("R4 last word reset", got_n, 32'h2402);
                   check("R4 last word no error", 32'(gerr_n), 0);
      wr(12'h1A4, 32'h5); rd(12'h1A4); check("R4 last word writable", got_n, 5);
   endtask

   task automatic t_align();
      wr(12'h00E, 32'h77); check("R1 misaligned write flagged", 32'(gerr_n), 1);
      rd(12'h00C); check("R1 misaligned write ignored", got_n, 32'h19FC_3E8B);
      rd(12'h00D); check("R1 misaligned read is 0", got_n, 0);
                   check("R1 misaligned read flagged", 32'(gerr_o), 1);
   endtask

   task automatic t_rng();
      rng_ref = SEED;
      for (int k = 0; k < 3; k++) begin
         rng_ref = lfsr_adv(rng_ref);
         rd(12'h078);
         check("R6 random word newer", got_n, rng_ref);
         check("R6 random word older", got_o, rng_ref);
      end
      wr(12'h074, 32'h0);
      rng_ref = lfsr_adv(rng_ref);
      rd(12'h078); check("R6 random with enable cleared", got_n, rng_ref);
   endtask

   task automatic t_strap();
      wr(12'h070, 32'h0003_0000);
      rd(12'h070); check("R7 strap OR on newer", got_n, 32'h0003_0F00);
                   check("R8 strap store on older", got_o, 32'h0003_0000);
      wr(12'h07C, 32'h0000_0300);
      check("R7 rev write no error newer", 32'(gerr_n), 0);
      check("R8 rev write flagged older", 32'(gerr_o), 1);
      rd(12'h070); check("R7 strap cleared via rev", got_n, 32'h0003_0C00);
                   check("R8 strap untouched older", got_o, 32'h0003_0000);
      rd(12'h07C); check("R7 rev unchanged newer", got_n, REV_NEW);
                   check("R8 rev unchanged older", got_o, REV_OLD);
      wr(12'h000, 32'h0);
      wr(12'h070, 32'hFFFF_FFFF); check("R3 locked strap flagged", 32'(gerr_n), 1);
      rd(12'h070); check("R3 locked strap kept", got_n, 32'h0003_0C00);
      wr(12'h008, 32'h0); rd(12'h008); check("R2 relock blocks writes", got_n, 32'h0BAD_F00D);
      wr(12'h000, KEY);
   endtask

   task automatic t_wake();
      wr(12'h0C0, 32'h55); check("R10 wake write no error", 32'(gerr_n), 0);
      rd(12'h0C0); check("R10 wake read returns value", got_n, 32'h55);
                   check("R10 wake read flagged", 32'(gerr_n), 1);
   endtask

   task automatic t_err_reset();
      wr(12'h1A8, 32'h0); check("R11 pulse after bad access", 32'(gerr_n), 1);
      @(negedge clk); check("R11 pulse lasts one cycle", 32'(ep_n), 0);
                      check("R11 sticky held", 32'(es_n), 1);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check("R11 sticky cleared by reset", 32'(es_o), 0);
      rd(12'h000); check("R9 key reloaded", got_n, 0);
      rd(12'h0C0); check("R9 wake word reset", got_n, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_vals();
      t_locked();
      t_key();
      t_readonly();
      t_bounds();
      t_align();
      t_rng();
      t_strap();
      t_wake();
      t_err_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule